// File: doc/BRIEF.md
# Token-Chained Serial Bus Interleaver

Several framers can share one serial backplane carrying data and signaling if they take turns. They pass a carry token down a daisy chain. This block is one link in that chain. The carry-in input idles high. When it rises, the block opens an access window on the system clock. For the length of the window, the block's receive data and signaling serial outputs are enabled. At the same time, the transmit data and signaling serial inputs are sampled, one bit per clock. When the last bit has been placed on the bus, the outputs go back to high impedance and carry-out is raised. That hands the bus to the next device in the chain.

A static mode input picks the window length: a byte window of 8 bits or a frame window of 256 bits. The outgoing bits come from a parallel source word that is snapshotted when the window opens, and they leave MSB first. The sampled bits are gathered into a capture register, and a one-cycle done pulse marks the end of the window. The output enables come out as separate ports, so the pad ring can build the tristate drivers. While the enables are low, the serial data ports are held at 0.

Top module: `tdm_chain_interleaver`

## Requirements
- R1: While `rst_n` is low (asynchronous assertion), `rx_oe`, `carry_out`, `cap_done`, `rx_data` and `rx_sig` are all 0. Once `rst_n` is released, the block stays idle.
- R2: Holding `carry_in` high, which is its idle level, never opens a window. This holds through reset and after it.
- R3: A rising edge on `carry_in` opens a window. `rx_oe` becomes 1 after the third rising clock edge that samples `carry_in` high. That edge is also the first edge at which `tx_data` and `tx_sig` are not yet sampled; sampling starts on the next edge.
- R4: `frame_mode` = 0 gives an 8-bit window and `frame_mode` = 1 gives a 256-bit window, so `rx_oe` stays high for exactly 8 or 256 cycles. The mode is taken at the window start, and a change during a window has no effect on that window.
- R5: During window cycle j, counted from 0, `rx_data` and `rx_sig` carry bit (L-1-j) of the source word snapshotted at the start. In frame mode L = 256 and the whole of `src_data` and `src_sig` is used. In byte mode L = 8 and only bits [7:0] are used. Source changes during a window have no effect on that window.
- R6: The input bits are sampled on the clock edge that ends each window cycle. In frame mode, the bit sampled in cycle j lands in `cap_data`/`cap_sig` bit 255-j. In byte mode it lands in bit 7-j, and bits [255:8] read 0.
- R7: On the clock edge after the last bit, `rx_oe` falls, `carry_out` rises and `cap_done` pulses high for exactly one cycle. While `rx_oe` is low, `rx_data` and `rx_sig` read 0.
- R8: `carry_out` stays high until the next accepted `carry_in` rising edge opens a new window. It falls in the same cycle that `rx_oe` rises.
- R9: A `carry_in` rising edge that is seen while a window is open is ignored. It neither restarts nor extends the window, and it does not open a new one afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| carry_in | input | 1 | Token input from the previous device, idles high |
| frame_mode | input | 1 | Window length select: 0 = 8 bits, 1 = 256 bits |
| src_data | input | 256 | Parallel data word to send on the bus |
| src_sig | input | 256 | Parallel signaling word to send on the bus |
| tx_data | input | 1 | Serial data sampled from the bus |
| tx_sig | input | 1 | Serial signaling sampled from the bus |
| rx_data | output | 1 | Serial data driven onto the bus (0 when disabled) |
| rx_sig | output | 1 | Serial signaling driven onto the bus (0 when disabled) |
| rx_oe | output | 1 | Output enable for the rx_data and rx_sig pad drivers |
| carry_out | output | 1 | Token output to the next device |
| cap_data | output | 256 | Captured data bits of the last window |
| cap_sig | output | 256 | Captured signaling bits of the last window |
| cap_done | output | 1 | One-cycle pulse when a window completes |

## Verification
The byte window is swept over all 256 byte values. The signaling lane and the sampled input use different functions of each value, so a swapped lane, a reversed bit order or a shift off by one gives a wrong word. Frame windows use full 256-bit arithmetic patterns, which expose a truncated length and an incorrect byte-mode load. Disturbed windows do three things mid-window: flip the mode, rewrite the source and pulse carry-in. These separate a latched configuration from a live one. Runs with carry-in held idle and a reset during a window confirm that nothing starts without a true rising edge.

// File: rtl/tdmi_pkg.sv
`timescale 1ns/1ps
package tdmi_pkg;
  typedef enum logic {
    WIN_BYTE  = 1'b0,
    WIN_FRAME = 1'b1
  } win_len_e;
endpackage

// File: rtl/tdmi_cin_detect.sv
`timescale 1ns/1ps
// Brings the token input into the clock domain and flags its rising edge.
// The registers reset to 1, so an input held at its idle-high level
// never produces an edge.
module tdmi_cin_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cin,
  output logic rise_o
);
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   prev_q, prev_d;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_comb sync_d = cin;
    end else begin : g_chain
      always_comb sync_d = {sync_q[SYNC_STAGES-2:0], cin};
    end
  endgenerate

  always_comb begin
    prev_d = sync_q[SYNC_STAGES-1];
    rise_o = sync_q[SYNC_STAGES-1] & ~prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end
endmodule

// File: rtl/tdmi_window_ctrl.sv
`timescale 1ns/1ps
// Keeps track of window ownership: the start, the bit count, the token hand-off and the done pulse.
module tdmi_window_ctrl
  import tdmi_pkg::*;
#(
  parameter int FRAME_BITS = 256,
  parameter int BYTE_BITS  = 8
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start_req,
  input  win_len_e mode,
  output logic     active_o,
  output logic     load_o,
  output logic     co_o,
  output logic     done_o
);
  localparam int CW = $clog2(FRAME_BITS);
  localparam logic [CW-1:0] LAST_FRAME = CW'(FRAME_BITS - 1);
  localparam logic [CW-1:0] LAST_BYTE  = CW'(BYTE_BITS - 1);

  logic          active_q, active_d;
  logic [CW-1:0] cnt_q, cnt_d;
  win_len_e      sel_q, sel_d;
  logic          co_q, co_d;
  logic          done_q, done_d;
  logic          start;
  logic [CW-1:0] last_idx;

  always_comb begin
    start    = start_req & ~active_q;
    last_idx = (sel_q == WIN_FRAME) ? LAST_FRAME : LAST_BYTE;
    active_d = active_q;
    cnt_d    = cnt_q;
    sel_d    = sel_q;
    co_d     = co_q;
    done_d   = 1'b0;
    if (start) begin
      active_d = 1'b1;
      cnt_d    = '0;
      sel_d    = mode;
      co_d     = 1'b0;
    end else if (active_q) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == last_idx) begin
        active_d = 1'b0;
        cnt_d    = '0;
        co_d     = 1'b1;
        done_d   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      sel_q    <= WIN_BYTE;
      co_q     <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
      sel_q    <= sel_d;
      co_q     <= co_d;
      done_q   <= done_d;
    end
  end

  assign active_o = active_q;
  assign load_o   = start;
  assign co_o     = co_q;
  assign done_o   = done_q;
endmodule

// File: rtl/tdmi_lane.sv
`timescale 1ns/1ps
// One serial lane: it loads a parallel word and shifts it out MSB first,
// and it shifts the sampled input bits into a capture word.
module tdmi_lane
  import tdmi_pkg::*;
#(
  parameter int FRAME_BITS = 256,
  parameter int BYTE_BITS  = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  win_len_e              mode,
  input  logic                  shift_en,
  input  logic [FRAME_BITS-1:0] src,
  input  logic                  ser_in,
  output logic                  ser_out,
  output logic [FRAME_BITS-1:0] cap
);
  localparam int PAD = FRAME_BITS - BYTE_BITS;

  logic [FRAME_BITS-1:0] shreg_q, shreg_d;
  logic [FRAME_BITS-1:0] cap_q, cap_d;

  always_comb begin
    shreg_d = shreg_q;
    cap_d   = cap_q;
    if (load) begin
      shreg_d = (mode == WIN_FRAME) ? src : {src[BYTE_BITS-1:0], {PAD{1'b0}}};
      cap_d   = '0;
    end else if (shift_en) begin
      shreg_d = {shreg_q[FRAME_BITS-2:0], 1'b0};
      cap_d   = {cap_q[FRAME_BITS-2:0], ser_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      cap_q   <= '0;
    end else begin
      shreg_q <= shreg_d;
      cap_q   <= cap_d;
    end
  end

  assign ser_out = shreg_q[FRAME_BITS-1];
  assign cap     = cap_q;
endmodule

// File: rtl/tdm_chain_interleaver.sv
`timescale 1ns/1ps
module tdm_chain_interleaver
  import tdmi_pkg::*;
#(
  parameter int FRAME_BITS  = 256,
  parameter int BYTE_BITS   = 8,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  carry_in,
  input  logic                  frame_mode,
  input  logic [FRAME_BITS-1:0] src_data,
  input  logic [FRAME_BITS-1:0] src_sig,
  input  logic                  tx_data,
  input  logic                  tx_sig,
  output logic                  rx_data,
  output logic                  rx_sig,
  output logic                  rx_oe,
  output logic                  carry_out,
  output logic [FRAME_BITS-1:0] cap_data,
  output logic [FRAME_BITS-1:0] cap_sig,
  output logic                  cap_done
);
  localparam int LANES = 2;

  // The reset asserts asynchronously and releases on a clock edge.
  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[RST_STAGES-1];

  logic     cin_rise, win_active, win_load;
  win_len_e mode_sel;

  assign mode_sel = win_len_e'(frame_mode);

  tdmi_cin_detect #(.SYNC_STAGES(SYNC_STAGES)) cin_i (
    .clk(clk), .rst_n(rst_sync_n), .cin(carry_in), .rise_o(cin_rise)
  );

  tdmi_window_ctrl #(.FRAME_BITS(FRAME_BITS), .BYTE_BITS(BYTE_BITS)) ctrl_i (
    .clk(clk), .rst_n(rst_sync_n), .start_req(cin_rise), .mode(mode_sel),
    .active_o(win_active), .load_o(win_load), .co_o(carry_out), .done_o(cap_done)
  );

  logic [LANES-1:0][FRAME_BITS-1:0] lane_src, lane_cap;
  logic [LANES-1:0]                 lane_in, lane_out;

  assign lane_src[0] = src_data;
  assign lane_src[1] = src_sig;
  assign lane_in[0]  = tx_data;
  assign lane_in[1]  = tx_sig;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    tdmi_lane #(.FRAME_BITS(FRAME_BITS), .BYTE_BITS(BYTE_BITS)) lane_i (
      .clk(clk), .rst_n(rst_sync_n), .load(win_load), .mode(mode_sel),
      .shift_en(win_active), .src(lane_src[g]), .ser_in(lane_in[g]),
      .ser_out(lane_out[g]), .cap(lane_cap[g])
    );
  end

  assign rx_oe    = win_active;
  assign rx_data  = win_active & lane_out[0];
  assign rx_sig   = win_active & lane_out[1];
  assign cap_data = lane_cap[0];
  assign cap_sig  = lane_cap[1];
endmodule

// File: rtl/tdmi_checker.sv
`timescale 1ns/1ps
module tdmi_checker #(
  parameter int FRAME_BITS = 256,
  parameter int BYTE_BITS  = 8
) (
  input logic clk,
  input logic rst_n,
  input logic carry_in,
  input logic frame_mode,
  input logic rx_oe,
  input logic carry_out,
  input logic cap_done
);
  localparam int RW = $clog2(FRAME_BITS) + 1;

  logic [RW-1:0] run_cnt;
  logic          oe_d, mode_d, exp_frame;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt   <= '0;
      oe_d      <= 1'b0;
      mode_d    <= 1'b0;
      exp_frame <= 1'b0;
    end else begin
      oe_d   <= rx_oe;
      mode_d <= frame_mode;
      if (rx_oe) run_cnt <= run_cnt + 1'b1;
      else       run_cnt <= '0;
      if (rx_oe && !oe_d) exp_frame <= mode_d;
    end
  end

  // R3: a window opens only after carry_in has been low and then high through the synchronizer
  assert_start_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_oe) |-> ($past(carry_in, 3) && !$past(carry_in, 4)));

  // R4: window length matches the mode in force at the start
  assert_window_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_oe) |-> (run_cnt == (exp_frame ? RW'(FRAME_BITS) : RW'(BYTE_BITS))));

  // R7: driver enable and token output are never high together
  assert_oe_co_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_oe && carry_out));

  // R7: done lasts a single cycle
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cap_done |=> !cap_done);

  // R7: the token is handed on together with the done pulse, right after the window
  assert_co_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(carry_out) |-> (cap_done && $fell(rx_oe)));

  // R8: the token drops only when a new window opens
  assert_co_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(carry_out) |-> $rose(rx_oe));
endmodule

bind tdm_chain_interleaver tdmi_checker #(
  .FRAME_BITS(FRAME_BITS), .BYTE_BITS(BYTE_BITS)
) chk_i (
  .clk(clk), .rst_n(rst_n), .carry_in(carry_in), .frame_mode(frame_mode),
  .rx_oe(rx_oe), .carry_out(carry_out), .cap_done(cap_done)
);

// File: tb/tdm_chain_interleaver_tb_top.sv
`timescale 1ns/1ps
module tdm_chain_interleaver_tb_top;
  localparam int FB = 256;
  localparam int BB = 8;

  logic          clk, rst_n, carry_in, frame_mode, tx_data, tx_sig;
  logic [FB-1:0] src_data, src_sig, cap_data, cap_sig;
  logic          rx_data, rx_sig, rx_oe, carry_out, cap_done;

  int checks = 0;
  int errors = 0;
  logic exp_co = 1'b0;

  tdm_chain_interleaver #(.FRAME_BITS(FB), .BYTE_BITS(BB)) dut_i (
    .clk(clk), .rst_n(rst_n), .carry_in(carry_in), .frame_mode(frame_mode),
    .src_data(src_data), .src_sig(src_sig), .tx_data(tx_data), .tx_sig(tx_sig),
    .rx_data(rx_data), .rx_sig(rx_sig), .rx_oe(rx_oe), .carry_out(carry_out),
    .cap_data(cap_data), .cap_sig(cap_sig), .cap_done(cap_done)
  );

  initial begin
    clk = 1'b0;
    forever #10 clk = ~clk;
  end

  task automatic chk(input string req, input logic [FB-1:0] act, input logic [FB-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [FB-1:0] pat(input int seed);
    logic [FB-1:0] v;
    for (int k = 0; k < FB / 32; k++)
      v[k*32 +: 32] = (32'h9E3779B9 * (seed + k + 1)) ^ (32'(seed) << k);
    return v;
  endfunction

  task automatic idle_checks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk("R2 no window while idle", rx_oe, 0);
      chk("R7 outputs low when disabled", {rx_data, rx_sig}, 0);
      chk("R8 carry_out held", carry_out, exp_co);
      chk("R7 done low when idle", cap_done, 0);
    end
  endtask

  // Open one window and follow it bit by bit. With disturb set, the mode
  // and sources change mid-window and carry_in is pulsed again (R4 R5 R9).
  task automatic run_window(input logic mode, input logic [FB-1:0] sd, input logic [FB-1:0] ss,
                            input logic [FB-1:0] td, input logic [FB-1:0] ts, input logic disturb);
    int len;
    logic [FB-1:0] exp_cd, exp_cs;
    len = mode ? FB : BB;
    @(negedge clk);
    frame_mode = mode; src_data = sd; src_sig = ss; carry_in = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk("R8 carry_out held before start", carry_out, exp_co);
    end
    carry_in = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R3 no enable before third edge", rx_oe, 0);
    @(posedge clk);
    @(negedge clk);
    chk("R3 enable after third edge", rx_oe, 1);
    chk("R8 carry_out falls at start", carry_out, 0);
    for (int j = 0; j < len; j++) begin
      int idx;
      idx = len - 1 - j;
      chk("R4 enable held in window", rx_oe, 1);
      chk("R5 rx_data bit", rx_data, sd[idx]);
      chk("R5 rx_sig bit", rx_sig, ss[idx]);
      tx_data = td[idx];
      tx_sig  = ts[idx];
      if (disturb) begin
        if (j == 1) begin
          frame_mode = ~mode; src_data = ~sd; src_sig = ~ss; carry_in = 1'b0;
        end
        if (j == 4) carry_in = 1'b1;
      end
      @(posedge clk);
      @(negedge clk);
    end
    exp_co = 1'b1;
    if (mode) begin
      exp_cd = td; exp_cs = ts;
    end else begin
      exp_cd = {{(FB-BB){1'b0}}, td[BB-1:0]};
      exp_cs = {{(FB-BB){1'b0}}, ts[BB-1:0]};
    end
    chk("R4 window closes after length", rx_oe, 0);
    chk("R7 carry_out rises", carry_out, 1);
    chk("R7 done pulse", cap_done, 1);
    chk("R7 outputs low after window", {rx_data, rx_sig}, 0);
    chk("R6 capture data", cap_data, exp_cd);
    chk("R6 capture sig", cap_sig, exp_cs);
    @(negedge clk);
    chk("R7 done one cycle", cap_done, 0);
    idle_checks(4);
    chk("R9 capture unchanged after ignored edge", cap_data, exp_cd);
  endtask

  initial begin
    rst_n = 1'b0; carry_in = 1'b1; frame_mode = 1'b0;
    src_data = '0; src_sig = '0; tx_data = 1'b0; tx_sig = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 reset oe", rx_oe, 0);
    chk("R1 reset carry_out", carry_out, 0);
    chk("R1 reset done", cap_done, 0);
    chk("R1 reset serial outs", {rx_data, rx_sig}, 0);
    rst_n = 1'b1;
    idle_checks(20);

    // Every byte value in byte mode.
    for (int b = 0; b < 256; b++) begin
      logic [FB-1:0] sd, ss, td, ts;
      sd = pat(b) ^ FB'(b);
      ss = pat(b + 7) ^ FB'(8'(~b));
      td = pat(b + 3) ^ FB'(8'(b ^ 8'hA5));
      ts = pat(b + 5) ^ FB'(8'(b + 8'h3C));
      run_window(1'b0, sd, ss, td, ts, 1'b0);
    end
    // Frame windows with several patterns.
    for (int s = 1; s <= 3; s++)
      run_window(1'b1, pat(s * 11), ~pat(s * 13), pat(s * 17), pat(s * 19) ^ {FB/2{2'b10}}, 1'b0);
    run_window(1'b1, '1, '0, {FB/2{2'b01}}, '1, 1'b0);
    // Disturbed windows, then a mode change between windows.
    run_window(1'b0, pat(40), pat(41), pat(42), pat(43), 1'b1);
    run_window(1'b1, pat(50), pat(51), pat(52), pat(53), 1'b1);
    run_window(1'b0, pat(60), pat(61), pat(62), pat(63), 1'b0);
    run_window(1'b1, pat(70), pat(71), pat(72), pat(73), 1'b0);

    // Reset during a window, with carry_in left high.
    @(negedge clk);
    frame_mode = 1'b1; carry_in = 1'b0;
    repeat (3) @(negedge clk);
    carry_in = 1'b1;
    repeat (10) @(negedge clk);
    chk("R3 window open before reset", rx_oe, 1);
    rst_n = 1'b0;
    #1;
    chk("R1 async reset oe", rx_oe, 0);
    chk("R1 async reset carry_out", carry_out, 0);
    chk("R1 async reset serial outs", {rx_data, rx_sig}, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    exp_co = 1'b0;
    idle_checks(30);
    run_window(1'b0, pat(80), pat(81), pat(82), pat(83), 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule